// File: doc/BRIEF.md
# Cascadable Configuration Memory Sequencer

This block is the read path of a configuration store that feeds a programmable-logic device. It holds a small word array and walks through it with an address counter, one step per rising clock. In serial mode it presents one bit per clock on the lowest data line, starting with the most significant bit of each word. In byte-wide mode it presents a whole word per clock. The counter runs only while the active-low chip enable is low and the reset/enable input is high. Driving that input low returns the counter to the first bit and turns the data lines off.

Several instances can share a clock and a data bus. Each instance drives a chain output into the chip enable of the next one. When an instance has delivered its last bit, the next clock moves it to a spent condition: its data lines turn off and its chain output asserts, which enables the following instance. The assertion level of the chain output is a parameter. A simple synchronous write port fills the array.

The sequencer has three states:
- ST_HELD: the reset/enable input is low, or it has just risen.
- ST_READ: counting.
- ST_SPENT: past the terminal count.

Its transitions are:
- HELD→READ on the first clock with the reset/enable input high.
- HELD or READ→SPENT on an advancing clock at the last bit (the last word in byte-wide mode).
- Any state→HELD, asynchronously, when the reset/enable input goes low.

Top module: `cfgmem_seq`

## Requirements
- R1: The read position advances on a rising `clk` only when `ce_n` is 0 and `oe_rst_n` is 1. A clock with `ce_n` at 1 leaves the position unchanged.
- R2: While `oe_rst_n` is 0, the read position is held at word 0, bit 0, and `data_oe` is 0. After it returns to 1, reading restarts from the first bit.
- R3: While `ce_n` is 1, `data_oe` is 0, whatever the value of `oe_rst_n`.
- R4: After the terminal count has been passed, the read position stops changing and `data_oe` stays 0 until `oe_rst_n` goes low.
- R5: The chain output asserts when `oe_rst_n` is 1, `ce_n` is 0 and the terminal count has been passed. This happens on the clock after the last bit, in the same cycle in which `data_oe` falls.
- R6: After the terminal count has been passed, the chain output follows `ce_n` for as long as `oe_rst_n` stays 1.
- R7: When `oe_rst_n` goes low, the chain output deasserts. It stays deasserted after `oe_rst_n` returns high, until the array has been read through again.
- R8: With `CEO_ACTIVE_HIGH` = 1, the asserted level of `ceo` is 1. With `CEO_ACTIVE_HIGH` = 0, the asserted level is 0.
- R9: In serial mode (`mode_byte` = 0), the following apply:
  - `data_o[0]` carries bit WORD_W-1-b of word w, where w is the word index and b the bit index.
  - `data_o[WORD_W-1:1]` is 0.
  - The terminal count is DEPTH*WORD_W-1 bit positions.
- R10: In byte-wide mode (`mode_byte` = 1), `data_o` carries word w whole, and the word index steps once per clock over DEPTH clocks.
- R11: A rising `clk` with `wr_en` = 1 stores `wr_data` at `wr_addr`, and later reads deliver the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read and write clock |
| oe_rst_n | input | 1 | High: output enable. Low: asynchronous counter reset |
| ce_n | input | 1 | Active-low chip enable; high means standby |
| mode_byte | input | 1 | 0 for serial output, 1 for word-wide output |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | AW | Array write word index |
| wr_data | input | WORD_W | Array write data |
| data_o | output | WORD_W | Read data, 0 when not enabled |
| data_oe | output | 1 | Drive enable for `data_o` |
| ceo | output | 1 | Chain output to the next instance's `ce_n` |

## Verification
The assertions assume that `mode_byte` does not change during a read pass, and that the array is written only while `oe_rst_n` is low. The stimulus keeps both of these conditions. It changes inputs only just after a falling clock edge, so the asynchronous reset never moves near a rising edge. Two instances are chained, one with each chain polarity, and they are read through fully in both modes. Standby, reset and the follow-enable phases are inserted at chosen bit positions, and the expected bits come from a bench copy of the array contents.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

    typedef enum logic [1:0] {
        ST_HELD  = 2'd0,
        ST_READ  = 2'd1,
        ST_SPENT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/cfgmem_array.sv
module cfgmem_array #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);

    logic [WORD_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_word = store_q[rd_addr];
    end

endmodule

// File: rtl/cfgmem_addr.sv
module cfgmem_addr
    import cfgmem_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 8,
    parameter int AW     = 4,
    parameter int BW     = 3
) (
    input  logic          clk,
    input  logic          oe_rst_n,
    input  logic          ce_n,
    input  logic          mode_byte,
    output logic [AW-1:0] word_idx,
    output logic [BW-1:0] bit_idx,
    output logic          spent
);

    localparam logic [AW-1:0] LAST_WORD = AW'(DEPTH - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W - 1);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       step;
    logic       at_end;

    always_comb begin
        step   = oe_rst_n && !ce_n;
        at_end = (word_idx == LAST_WORD) && (mode_byte || (bit_idx == LAST_BIT));
    end

    // state register
    always_ff @(posedge clk or negedge oe_rst_n) begin
        if (!oe_rst_n) begin
            state_q <= ST_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HELD: begin
                state_d = (step && at_end) ? ST_SPENT : ST_READ;
            end
            ST_READ: begin
                if (step && at_end) begin
                    state_d = ST_SPENT;
                end
            end
            ST_SPENT: begin
                state_d = ST_SPENT;
            end
            default: begin
                state_d = ST_HELD;
            end
        endcase
    end

    // read position
    always_ff @(posedge clk or negedge oe_rst_n) begin
        if (!oe_rst_n) begin
            word_idx <= '0;
            bit_idx  <= '0;
        end else if (step && (state_q != ST_SPENT) && !at_end) begin
            if (mode_byte) begin
                word_idx <= word_idx + 1'b1;
            end else if (bit_idx == LAST_BIT) begin
                bit_idx  <= '0;
                word_idx <= word_idx + 1'b1;
            end else begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // outputs of the state machine
    always_comb begin
        spent = (state_q == ST_SPENT);
    end

endmodule

// File: rtl/cfgmem_drive.sv
module cfgmem_drive #(
    parameter int WORD_W          = 8,
    parameter int BW              = 3,
    parameter bit CEO_ACTIVE_HIGH = 1'b0
) (
    input  logic              oe_rst_n,
    input  logic              ce_n,
    input  logic              mode_byte,
    input  logic              spent,
    input  logic [BW-1:0]     bit_idx,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] data_o,
    output logic              data_oe,
    output logic              ceo
);

    localparam logic [BW-1:0] TOP_BIT = BW'(WORD_W - 1);

    logic serial_bit;
    logic chain_act;

    always_comb begin
        data_oe    = oe_rst_n && !ce_n && !spent;
        serial_bit = rd_word[TOP_BIT - bit_idx];
        chain_act  = oe_rst_n && !ce_n && spent;
        if (!data_oe) begin
            data_o = '0;
        end else if (mode_byte) begin
            data_o = rd_word;
        end else begin
            data_o = {{(WORD_W-1){1'b0}}, serial_bit};
        end
    end

    generate
        if (CEO_ACTIVE_HIGH) begin : g_ceo_high
            assign ceo = chain_act;
        end else begin : g_ceo_low
            assign ceo = !chain_act;
        end
    endgenerate

endmodule

// File: rtl/cfgmem_seq.sv
module cfgmem_seq #(
    parameter int  DEPTH           = 16,
    parameter int  WORD_W          = 8,
    parameter bit  CEO_ACTIVE_HIGH = 1'b0,
    localparam int AW              = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int BW              = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
    input  logic              clk,
    input  logic              oe_rst_n,
    input  logic              ce_n,
    input  logic              mode_byte,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] data_o,
    output logic              data_oe,
    output logic              ceo
);

    logic [AW-1:0]     word_idx;
    logic [BW-1:0]     bit_idx;
    logic              spent;
    logic [WORD_W-1:0] rd_word;

    cfgmem_array #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) u_array (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (word_idx),
        .rd_word (rd_word)
    );

    cfgmem_addr #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW), .BW(BW)) u_addr (
        .clk       (clk),
        .oe_rst_n  (oe_rst_n),
        .ce_n      (ce_n),
        .mode_byte (mode_byte),
        .word_idx  (word_idx),
        .bit_idx   (bit_idx),
        .spent     (spent)
    );

    cfgmem_drive #(.WORD_W(WORD_W), .BW(BW), .CEO_ACTIVE_HIGH(CEO_ACTIVE_HIGH)) u_drive (
        .oe_rst_n  (oe_rst_n),
        .ce_n      (ce_n),
        .mode_byte (mode_byte),
        .spent     (spent),
        .bit_idx   (bit_idx),
        .rd_word   (rd_word),
        .data_o    (data_o),
        .data_oe   (data_oe),
        .ceo       (ceo)
    );

endmodule

// File: rtl/cfgmem_seq_chk.sv
module cfgmem_seq_chk #(
    parameter int WORD_W          = 8,
    parameter int CNT_W           = 7,
    parameter bit CEO_ACTIVE_HIGH = 1'b0
) (
    input logic              clk,
    input logic              oe_rst_n,
    input logic              ce_n,
    input logic              mode_byte,
    input logic [WORD_W-1:0] data_o,
    input logic              data_oe,
    input logic              ceo,
    input logic              spent,
    input logic [CNT_W-1:0]  cnt
);

    logic ceo_on;
    always_comb ceo_on = CEO_ACTIVE_HIGH ? ceo : !ceo;

    AST_HOLD_IN_STANDBY: assert property (@(posedge clk) disable iff (!oe_rst_n) ce_n |=> $stable(cnt)); // R1
    AST_RESET_CLEARS: assert property (@(posedge clk) !oe_rst_n |-> (!data_oe && cnt == '0)); // R2
    AST_STANDBY_QUIET: assert property (@(posedge clk) ce_n |-> !data_oe); // R3
    AST_SPENT_STICKS: assert property (@(posedge clk) disable iff (!oe_rst_n) spent |=> (spent && $stable(cnt))); // R4
    AST_CHAIN_EXCLUSIVE: assert property (@(posedge clk) ceo_on |-> !data_oe); // R5
    AST_CHAIN_FOLLOWS: assert property (@(posedge clk) disable iff (!oe_rst_n) (spent && !ce_n) |-> ceo_on); // R6
    AST_CHAIN_RESET_OFF: assert property (@(posedge clk) !oe_rst_n |-> !ceo_on); // R7
    AST_SERIAL_UPPER_ZERO: assert property (@(posedge clk) (data_oe && !mode_byte) |-> ((data_o >> 1) == '0)); // R9

endmodule

bind cfgmem_seq cfgmem_seq_chk #(
    .WORD_W          (WORD_W),
    .CNT_W           (AW + BW),
    .CEO_ACTIVE_HIGH (CEO_ACTIVE_HIGH)
) u_chk (
    .clk       (clk),
    .oe_rst_n  (oe_rst_n),
    .ce_n      (ce_n),
    .mode_byte (mode_byte),
    .data_o    (data_o),
    .data_oe   (data_oe),
    .ceo       (ceo),
    .spent     (spent),
    .cnt       ({word_idx, bit_idx})
);

// File: tb/sim_cfgmem_seq.sv
`timescale 1ns/1ps
module sim_cfgmem_seq;

    localparam int DEPTH = 4;
    localparam int W     = 8;
    localparam int NB    = DEPTH * W;

    logic         clk = 1'b0;
    logic         oe_rst_n = 1'b0;
    logic         ce0_n = 1'b0;
    logic         mode_byte = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_d0 = '0;
    logic [W-1:0] wr_d1 = '0;
    logic [W-1:0] d0, d1;
    logic         oe0, oe1, ceo0, ceo1;
    logic [W-1:0] m0 [DEPTH];
    logic [W-1:0] m1 [DEPTH];
    int           n_chk = 0;
    int           n_fail = 0;

    always #10 clk = ~clk;

    // u0: chain output asserted low (R8); drives u1 enable
    cfgmem_seq #(.DEPTH(DEPTH), .WORD_W(W), .CEO_ACTIVE_HIGH(1'b0)) u0 (
        .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(ce0_n), .mode_byte(mode_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_d0),
        .data_o(d0), .data_oe(oe0), .ceo(ceo0)
    );

    // u1: chain output asserted high (R8)
    cfgmem_seq #(.DEPTH(DEPTH), .WORD_W(W), .CEO_ACTIVE_HIGH(1'b1)) u1 (
        .clk(clk), .oe_rst_n(oe_rst_n), .ce_n(ceo0), .mode_byte(mode_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_d1),
        .data_o(d1), .data_oe(oe1), .ceo(ceo1)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    function automatic logic sbit(input int dev, input int k);
        logic [W-1:0] wd;
        wd = (dev == 0) ? m0[k / W] : m1[k / W];
        return wd[W - 1 - (k % W)];
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            m0[i] = W'(8'hA5 ^ (i * 37));
            m1[i] = W'(8'h3C + i * 19);
        end
        @(negedge clk);
        #1;
        chk("R2 reset u0 data_oe", 32'(oe0), 0);
        chk("R2 reset u1 data_oe", 32'(oe1), 0);
        chk("R7 R8 reset u0 ceo (low-asserted)", 32'(ceo0), 1);
        chk("R7 R8 reset u1 ceo (high-asserted)", 32'(ceo1), 0);

        // R11 fill both arrays while held in reset
        for (int i = 0; i < DEPTH; i++) begin
            wr_en = 1'b1; wr_addr = 2'(i); wr_d0 = m0[i]; wr_d1 = m1[i];
            tick(1);
        end
        wr_en = 1'b0;

        // serial sweep across both chained instances
        oe_rst_n = 1'b1;
        #1;
        for (int k = 0; k < 2 * NB; k++) begin
            if (k < NB) begin
                chk("R9 u0 serial bit", 32'(d0[0]), 32'(sbit(0, k)));
                chk("R9 u0 serial upper lines", 32'(d0 >> 1), 0);
                chk("R5 u0 oe during read", 32'(oe0), 1);
                chk("R3 u1 quiet while chained off", 32'(oe1), 0);
            end else begin
                chk("R9 u1 serial bit", 32'(d1[0]), 32'(sbit(1, k - NB)));
                chk("R5 u0 handed over", 32'(oe0), 0);
                chk("R5 R8 u0 ceo asserted low", 32'(ceo0), 0);
                chk("R5 u1 ceo not yet", 32'(ceo1), 0);
            end
            tick(1);
        end
        chk("R5 R8 u1 ceo asserted high", 32'(ceo1), 1);
        chk("R5 u1 oe off after last", 32'(oe1), 0);

        // frozen after terminal count
        tick(3);
        chk("R4 u0 stays off", 32'(oe0), 0);
        chk("R4 u1 stays off", 32'(oe1), 0);
        chk("R4 u1 ceo held", 32'(ceo1), 1);

        // chain output follows enable
        ce0_n = 1'b1;
        #1;
        chk("R6 u0 ceo follows ce high", 32'(ceo0), 1);
        chk("R6 u1 ceo follows ce high", 32'(ceo1), 0);
        tick(1);
        ce0_n = 1'b0;
        #1;
        chk("R6 u0 ceo follows ce low", 32'(ceo0), 0);
        chk("R6 u1 ceo follows ce low", 32'(ceo1), 1);

        // reset: chain deasserts and stays so
        oe_rst_n = 1'b0;
        #1;
        chk("R7 u0 ceo off in reset", 32'(ceo0), 1);
        chk("R7 u1 ceo off in reset", 32'(ceo1), 0);
        chk("R2 u0 data off in reset", 32'(oe0), 0);
        tick(1);
        oe_rst_n = 1'b1;
        #1;
        chk("R7 u0 ceo stays off", 32'(ceo0), 1);
        chk("R7 u1 ceo stays off", 32'(ceo1), 0);
        chk("R2 restart oe", 32'(oe0), 1);
        chk("R2 restart at first bit", 32'(d0[0]), 32'(sbit(0, 0)));

        // standby holds position
        tick(2);
        chk("R1 advanced to bit 2", 32'(d0[0]), 32'(sbit(0, 2)));
        ce0_n = 1'b1;
        #1;
        chk("R3 standby quiet", 32'(oe0), 0);
        tick(3);
        chk("R3 standby still quiet", 32'(oe0), 0);
        ce0_n = 1'b0;
        #1;
        chk("R1 position held across standby", 32'(d0[0]), 32'(sbit(0, 2)));
        tick(1);
        chk("R1 resumes at bit 3", 32'(d0[0]), 32'(sbit(0, 3)));

        // R11 rewrite one word under reset
        oe_rst_n = 1'b0;
        m0[2] = 8'h5A;
        wr_en = 1'b1; wr_addr = 2'd2; wr_d0 = m0[2]; wr_d1 = m1[2];
        tick(1);
        wr_en = 1'b0;

        // word-wide sweep
        mode_byte = 1'b1;
        oe_rst_n = 1'b1;
        #1;
        for (int i = 0; i < 2 * DEPTH; i++) begin
            if (i < DEPTH) begin
                chk("R10 R11 u0 word", 32'(d0), 32'(m0[i]));
                chk("R10 u0 oe", 32'(oe0), 1);
            end else begin
                chk("R10 u1 word", 32'(d1), 32'(m1[i - DEPTH]));
                chk("R10 R5 u0 ceo asserted", 32'(ceo0), 0);
            end
            tick(1);
        end
        chk("R10 R5 u1 ceo after last word", 32'(ceo1), 1);
        chk("R4 u1 quiet after last word", 32'(oe1), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule